// File: doc/BRIEF.md
# Channel-Steered DDS Control Register Bank

This block is the control register file of a four-channel direct digital synthesizer. Software writes it through a plain parallel port: an address, a 32-bit data word and a write strobe. A channel-select register holds one enable bit per channel. The shared frequency, phase, amplitude and function addresses are steered to every channel whose enable bit is set when the write happens. One address range therefore serves all four channels, and a single write can broadcast to several of them.

Every channel register has a staging copy and an active copy. Writes land in staging only. A synchronous update strobe copies the staged set of all channels into the active set on one clock edge, so the tone settings change together. The channel-select register takes effect at once and never waits for the update strobe. The active words drive the synthesizer datapath. A channel whose active power-down bit is set presents zero tuning, phase and amplitude words.

A small controller sequences the commits. It has two states. ST_SYNCED means staging equals active. ST_HELD means a staged write is waiting. A staged write takes SYNCED to HELD (STAGE_WRITE). An update strobe without a simultaneous staged write takes HELD back to SYNCED (COMMIT). An update strobe that comes with a staged write commits and stays in HELD (COMMIT_AND_STAGE). Any other cycle keeps the present state (IDLE_HOLD). The commit pulse is issued only in ST_HELD.

Top module: `dds_reg_bank`

## Requirements
- R1: A write to address 0x00 loads bits 3:0 into the channel-select output (bit n enables channel n). The new value appears on the next clock with no update strobe. No other address changes it.
- R2: Writes to addresses 0x03, 0x04, 0x05 and 0x06 are stored only in the channels whose select bit is set in the cycle of the write. Other channels keep their values.
- R3: Address 0x04 carries a 32-bit frequency tuning word. Address 0x05 carries a phase word in bits 13:0, and its upper data bits are discarded.
- R4: A staged write is not visible on the outputs until an update strobe. Active outputs change only on the clock edge that samples the update strobe high.
- R5: One update strobe moves the staged values of all four channels to the active outputs on the same clock edge.
- R6: Address 0x06 carries a 10-bit amplitude scale in bits 9:0 and a scale-enable bit at bit 12.
- R7: Address 0x03 carries a 3-bit coarse data-align field in bits 18:16, a matched-delay enable at bit 22 and a channel power-down bit at bit 7.
- R8: A channel-register write made while no channel is selected is ignored, and so is a write to any unassigned address. Staging and active state are unchanged.
- R9: Master reset (synchronous, active high) clears every staged and active word to zero and sets the channel select to 4'b1111.
- R10: While a channel's active power-down bit is 1, its frequency, phase and amplitude outputs read zero and its power-down output is 1. Clearing the bit restores the stored words.
- R11: When a staged write and an update strobe occur in the same cycle, the update commits the staging content from before that write. The new write stays staged until the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mreset | input | 1 | Synchronous master reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 32 | Write data |
| upd_strobe | input | 1 | Update strobe: copy staging to active |
| ch_sel | output | 4 | Channel-select bits (bit n = channel n) |
| out_ftw | output | 128 | Active tuning words, channel n in bits 32n+31:32n |
| out_pow | output | 56 | Active phase words, 14 bits per channel |
| out_asf | output | 40 | Active amplitude scale, 10 bits per channel |
| out_asf_en | output | 4 | Active scale-enable per channel |
| out_align | output | 12 | Active coarse data-align, 3 bits per channel |
| out_mdly | output | 4 | Active matched-delay enable per channel |
| out_pd | output | 4 | Active power-down per channel |

## Verification
The bench changes the select mask between writes to catch misrouting. A design that ignored the mask, or latched it one write late, would leave the wrong channel changed. It reads the outputs between staging and update, where a design that wrote straight to active copies would show the new word too early. It issues a write and an update in the same cycle: a design that forwarded the incoming word would commit it at once instead of the older staged value. It also writes with an empty mask and to an unassigned address, then writes a power-down bit and clears it again. A design that ignored the mask, failed to gate a powered-down channel, or zeroed its stored words for good would show wrong outputs there.

// File: rtl/dds_bank_pkg.sv
package dds_bank_pkg;
    localparam int FTW_W = 32;
    localparam int POW_W = 14;
    localparam int ASF_W = 10;
    localparam int ALN_W = 3;

    localparam logic [7:0] ADR_SEL  = 8'h00;
    localparam logic [7:0] ADR_FUNC = 8'h03;
    localparam logic [7:0] ADR_FTW  = 8'h04;
    localparam logic [7:0] ADR_POW  = 8'h05;
    localparam logic [7:0] ADR_AMP  = 8'h06;

    localparam int PD_BIT     = 7;
    localparam int ALN_LSB    = 16;
    localparam int MDLY_BIT   = 22;
    localparam int ASF_EN_BIT = 12;

    typedef enum logic [2:0] {
        FLD_NONE, FLD_SEL, FLD_FUNC, FLD_FTW, FLD_POW, FLD_AMP
    } field_e;

    typedef enum logic {
        ST_SYNCED, ST_HELD
    } bank_state_e;

    typedef struct packed {
        logic             pd;
        logic             mdly;
        logic [ALN_W-1:0] align;
        logic             asf_en;
        logic [ASF_W-1:0] asf;
        logic [POW_W-1:0] pow;
        logic [FTW_W-1:0] ftw;
    } chan_word_t;
endpackage

// File: rtl/dds_bank_ctrl.sv
module dds_bank_ctrl
    import dds_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           mreset,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           upd_strobe,
    output logic [NCH-1:0] ch_sel,
    output field_e         fld,
    output logic [NCH-1:0] stage_mask,
    output logic           commit
);
    bank_state_e state, state_nxt;
    logic        stage_hit;

    always_comb begin
        unique case (wr_addr)
            AW'(ADR_SEL):  fld = FLD_SEL;
            AW'(ADR_FUNC): fld = FLD_FUNC;
            AW'(ADR_FTW):  fld = FLD_FTW;
            AW'(ADR_POW):  fld = FLD_POW;
            AW'(ADR_AMP):  fld = FLD_AMP;
            default:       fld = FLD_NONE;
        endcase
    end

    assign stage_hit  = wr_en && (fld != FLD_NONE) && (fld != FLD_SEL) && (|ch_sel);
    assign stage_mask = stage_hit ? ch_sel : '0;

    always_ff @(posedge clk) begin
        if (mreset) begin
            ch_sel <= '1;
        end else if (wr_en && fld == FLD_SEL) begin
            ch_sel <= wr_data[NCH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (mreset) state <= ST_SYNCED;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SYNCED: if (stage_hit) state_nxt = ST_HELD;
            ST_HELD:   if (upd_strobe && !stage_hit) state_nxt = ST_SYNCED;
            default:   state_nxt = ST_SYNCED;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            ST_SYNCED: commit = 1'b0;
            ST_HELD:   commit = upd_strobe;
            default:   commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dds_chan_regs.sv
module dds_chan_regs
    import dds_bank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic       clk,
    input  logic       mreset,
    input  logic       ld,
    input  field_e     fld,
    input  logic [DW-1:0] wdata,
    input  logic       commit,
    output chan_word_t act_o
);
    chan_word_t stg_q, act_q;

    always_ff @(posedge clk) begin
        if (mreset) begin
            stg_q <= '0;
            act_q <= '0;
        end else begin
            if (commit) act_q <= stg_q;
            if (ld) begin
                unique case (fld)
                    FLD_FUNC: begin
                        stg_q.pd    <= wdata[PD_BIT];
                        stg_q.mdly  <= wdata[MDLY_BIT];
                        stg_q.align <= wdata[ALN_LSB +: ALN_W];
                    end
                    FLD_FTW: stg_q.ftw <= wdata[FTW_W-1:0];
                    FLD_POW: stg_q.pow <= wdata[POW_W-1:0];
                    FLD_AMP: begin
                        stg_q.asf    <= wdata[ASF_W-1:0];
                        stg_q.asf_en <= wdata[ASF_EN_BIT];
                    end
                    default: stg_q <= stg_q;
                endcase
            end
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
    import dds_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic                 clk,
    input  logic                 mreset,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 upd_strobe,
    output logic [NCH-1:0]       ch_sel,
    output logic [NCH*FTW_W-1:0] out_ftw,
    output logic [NCH*POW_W-1:0] out_pow,
    output logic [NCH*ASF_W-1:0] out_asf,
    output logic [NCH-1:0]       out_asf_en,
    output logic [NCH*ALN_W-1:0] out_align,
    output logic [NCH-1:0]       out_mdly,
    output logic [NCH-1:0]       out_pd
);
    field_e         fld;
    logic [NCH-1:0] stage_mask;
    logic           commit;

    dds_bank_ctrl #(.NCH(NCH), .AW(AW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .mreset     (mreset),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .upd_strobe (upd_strobe),
        .ch_sel     (ch_sel),
        .fld        (fld),
        .stage_mask (stage_mask),
        .commit     (commit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_word_t act;

        dds_chan_regs #(.DW(DW)) u_regs (
            .clk    (clk),
            .mreset (mreset),
            .ld     (stage_mask[c]),
            .fld    (fld),
            .wdata  (wr_data),
            .commit (commit),
            .act_o  (act)
        );

        assign out_ftw[c*FTW_W +: FTW_W]   = act.pd ? '0 : act.ftw;
        assign out_pow[c*POW_W +: POW_W]   = act.pd ? '0 : act.pow;
        assign out_asf[c*ASF_W +: ASF_W]   = act.pd ? '0 : act.asf;
        assign out_asf_en[c]               = act.asf_en;
        assign out_align[c*ALN_W +: ALN_W] = act.align;
        assign out_mdly[c]                 = act.mdly;
        assign out_pd[c]                   = act.pd;
    end
endmodule

// File: rtl/dds_reg_bank_chk.sv
module dds_reg_bank_chk
    import dds_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input logic                 clk,
    input logic                 mreset,
    input logic                 wr_en,
    input logic [AW-1:0]        wr_addr,
    input logic [DW-1:0]        wr_data,
    input logic                 upd_strobe,
    input logic [NCH-1:0]       ch_sel,
    input logic [NCH*FTW_W-1:0] out_ftw,
    input logic [NCH*POW_W-1:0] out_pow,
    input logic [NCH*ASF_W-1:0] out_asf,
    input logic [NCH-1:0]       out_pd
);
    logic prev_rst;
    always_ff @(posedge clk) prev_rst <= mreset;

    always @(posedge clk) begin
        if (prev_rst === 1'b1) begin
            AST_RESET_STATE: assert (out_ftw == '0 && out_pow == '0 && ch_sel == '1); // R9
        end
    end

    AST_SEL_TAKES_AT_ONCE: assert property (@(posedge clk) disable iff (mreset)
        (wr_en && wr_addr == AW'(ADR_SEL)) |=> ch_sel == $past(wr_data[NCH-1:0])); // R1

    AST_SEL_KEPT: assert property (@(posedge clk) disable iff (mreset)
        !(wr_en && wr_addr == AW'(ADR_SEL)) |=> $stable(ch_sel)); // R1

    AST_ACTIVE_WAITS_UPDATE: assert property (@(posedge clk) disable iff (mreset)
        !upd_strobe |=> ($stable(out_ftw) && $stable(out_pow) && $stable(out_asf) && $stable(out_pd))); // R4

    for (genvar c = 0; c < NCH; c++) begin : g_pd
        AST_PD_SILENCES: assert property (@(posedge clk) disable iff (mreset)
            out_pd[c] |-> (out_ftw[c*FTW_W +: FTW_W] == '0 && out_pow[c*POW_W +: POW_W] == '0
                           && out_asf[c*ASF_W +: ASF_W] == '0)); // R10
    end
endmodule

bind dds_reg_bank dds_reg_bank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .mreset     (mreset),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .upd_strobe (upd_strobe),
    .ch_sel     (ch_sel),
    .out_ftw    (out_ftw),
    .out_pow    (out_pow),
    .out_asf    (out_asf),
    .out_pd     (out_pd)
);

// File: tb/dds_reg_bank_tb_top.sv
module dds_reg_bank_tb_top;
    logic         clk = 1'b0;
    logic         mreset;
    logic         wr_en;
    logic [7:0]   wr_addr;
    logic [31:0]  wr_data;
    logic         upd_strobe;
    logic [3:0]   ch_sel;
    logic [127:0] out_ftw;
    logic [55:0]  out_pow;
    logic [39:0]  out_asf;
    logic [3:0]   out_asf_en;
    logic [11:0]  out_align;
    logic [3:0]   out_mdly;
    logic [3:0]   out_pd;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dds_reg_bank dut_i (
        .clk(clk), .mreset(mreset), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_strobe(upd_strobe), .ch_sel(ch_sel),
        .out_ftw(out_ftw), .out_pow(out_pow), .out_asf(out_asf),
        .out_asf_en(out_asf_en), .out_align(out_align), .out_mdly(out_mdly),
        .out_pd(out_pd)
    );

    function automatic logic [31:0] ftw(int c); return out_ftw[c*32 +: 32]; endfunction
    function automatic logic [31:0] pow(int c); return 32'(out_pow[c*14 +: 14]); endfunction
    function automatic logic [31:0] asf(int c); return 32'(out_asf[c*10 +: 10]); endfunction
    function automatic logic [31:0] aln(int c); return 32'(out_align[c*3 +: 3]); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic upd();
        upd_strobe = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0;
    endtask

    task automatic do_reset();
        mreset = 1'b1;
        repeat (3) @(negedge clk);
        mreset = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 sel", 32'(ch_sel), 32'hF);
        for (int c = 0; c < 4; c++) begin
            check("R9 ftw", ftw(c), 0);
            check("R9 pow", pow(c), 0);
        end
    endtask

    task automatic t_broadcast();
        wr(8'h04, 32'h1234_5678);
        for (int c = 0; c < 4; c++) check("R4 staged hidden", ftw(c), 0);
        upd();
        for (int c = 0; c < 4; c++) check("R5 all channels", ftw(c), 32'h1234_5678);
    endtask

    task automatic t_steer();
        wr(8'h00, 32'h2);
        check("R1 sel immediate", 32'(ch_sel), 32'h2);
        wr(8'h04, 32'hA5A5_0001);
        wr(8'h00, 32'h8);
        wr(8'h05, 32'hFFFF_FFFF);
        upd();
        check("R2 ch1 ftw", ftw(1), 32'hA5A5_0001);
        check("R2 ch3 ftw", ftw(3), 32'h1234_5678);
        check("R2 ch0 ftw", ftw(0), 32'h1234_5678);
        check("R3 ch3 pow masked", pow(3), 32'h3FFF);
        check("R2 ch1 pow", pow(1), 0);
    endtask

    task automatic t_ignored();
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h05, 32'h0000_0001);
        upd();
        check("R8 ch0 ftw", ftw(0), 32'h1234_5678);
        check("R8 ch3 pow", pow(3), 32'h3FFF);
        wr(8'h00, 32'hF);
        wr(8'h07, 32'hFFFF_FFFF);
        upd();
        check("R8 unassigned ftw", ftw(2), 32'h1234_5678);
        check("R8 unassigned sel", 32'(ch_sel), 32'hF);
        wr(8'h03, 32'h0);
        upd();
        check("R8 staging kept ch1", ftw(1), 32'hA5A5_0001);
        check("R8 staging kept ch0", ftw(0), 32'h1234_5678);
    endtask

    task automatic t_amp();
        wr(8'h00, 32'h1);
        wr(8'h06, 32'h0000_F2AB);
        upd();
        check("R6 asf", asf(0), 32'h2AB);
        check("R6 asf en", 32'(out_asf_en[0]), 1);
        check("R6 ch1 asf", asf(1), 0);
    endtask

    task automatic t_func();
        wr(8'h03, 32'h0045_0000);
        upd();
        check("R7 align", aln(0), 5);
        check("R7 mdly", 32'(out_mdly[0]), 1);
        check("R7 pd clear", 32'(out_pd[0]), 0);
        check("R7 ch1 align", aln(1), 0);
    endtask

    task automatic t_pd();
        wr(8'h00, 32'h4);
        wr(8'h03, 32'h0000_0080);
        upd();
        check("R10 pd flag", 32'(out_pd[2]), 1);
        check("R10 ftw zero", ftw(2), 0);
        check("R10 pow zero", pow(2), 0);
        check("R10 neighbour", ftw(1), 32'hA5A5_0001);
        wr(8'h03, 32'h0);
        upd();
        check("R10 restored", ftw(2), 32'h1234_5678);
    endtask

    task automatic t_same_cycle();
        wr(8'h00, 32'h1);
        wr(8'h04, 32'h1111_1111);
        wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h2222_2222; upd_strobe = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; upd_strobe = 1'b0;
        check("R11 old committed", ftw(0), 32'h1111_1111);
        upd();
        check("R11 new follows", ftw(0), 32'h2222_2222);
    endtask

    task automatic t_mreset();
        do_reset();
        check("R9 sel after", 32'(ch_sel), 32'hF);
        check("R9 ftw after", ftw(0), 0);
        check("R9 align after", aln(0), 0);
        check("R9 mdly after", 32'(out_mdly[0]), 0);
        upd();
        check("R9 staging cleared", ftw(1), 0);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mreset = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; upd_strobe = 1'b0;
        @(negedge clk);
        do_reset();
        t_reset();
        t_broadcast();
        t_steer();
        t_ignored();
        t_amp();
        t_func();
        t_pd();
        t_same_cycle();
        t_mreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule